// File: doc/BRIEF.md
# Low-Power Idle Clock Divider

This block controls the clock enables of a processor core and its peripheral clock domains during power-saving idle. In normal running every derived enable is asserted on every input clock. An idle command starts one of two idle modes. In the gated mode only the core enable is removed, and the peripheral enables keep running. In the divided mode every derived enable (core, serial, clock output, timer) pulses once per n input clocks. n is chosen by a 2-bit select as one of 16, 32, 64 or 128.

An enabled interrupt ends either mode. The gated mode returns to full rate on the next clock. The divided mode remembers the interrupt and waits for the end of the divide period in progress, so the last slow pulse is never cut short. The interrupt therefore waits at most n input clocks. When either mode is left, a one-cycle resume pulse tells the core to continue with the instruction after the idle instruction.

Top module: `idlediv_ctrl`

## Requirements
- R1: After synchronous reset the block is running: all four enables are 1 and `resume` is 0.
- R2: While running, all four enables are 1 on every cycle, and `irq` has no effect: `resume` stays 0.
- R3: An `idle_cmd` sampled with `div_mode`=0 enters gated idle. From the next cycle `core_en` is 0 while `sclk_en`, `cout_en` and `tmr_en` stay 1.
- R4: In gated idle, an `irq` sampled at a clock edge gives `core_en`=1 and `resume`=1 in the cycle that follows that edge (wake latency 1).
- R5: An `idle_cmd` sampled with `div_mode`=1 enters divided idle. `div_sel` encodes n as 00=16, 01=32, 10=64, 11=128. All four enables are equal and are 1 only in cycles n, 2n, 3n, ... counted after the command edge.
- R6: In divided idle, an `irq` first sampled at the edge ending cycle d+1 after entry (d idle cycles already passed) gives `resume`=1 after exactly n - (d mod n) edges, which is never more than n. The cycle before `resume` carries a full enable pulse.
- R7: `resume` is a single-cycle pulse. In the cycle after it the block is running with all enables 1.
- R8: While in either idle mode, `idle_cmd`, `div_mode` and `div_sel` are ignored: the mode and divisor fixed at entry stay in force.
- R9: In divided idle, a one-cycle `irq` pulse is remembered until the end of the current divide period and wakes the block with the same latency as a held `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_cmd | input | 1 | Idle command strobe, taken only while running |
| div_mode | input | 1 | 0 = gated idle, 1 = divided idle |
| div_sel | input | 2 | Divisor select: 00=16, 01=32, 10=64, 11=128 |
| irq | input | 1 | Enabled interrupt pending |
| core_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | Serial clock enable |
| cout_en | output | 1 | Clock output enable |
| tmr_en | output | 1 | Timer clock enable |
| resume | output | 1 | One-cycle pulse on leaving idle |

## Verification
The bench sweeps every divisor. For each one it raises the interrupt at phases 0, 1, n/2, n-1, n, n+3 and 2n-1 cycles after entry, and compares the wake latency with n - (d mod n). A design that wakes as soon as the interrupt arrives would show a latency of 1 at every phase and cut the slow pulse short. A counter that is off by one would miss the value at the n-1 and n phases. Pulse counts during idle and per-cycle equality of the four enables catch a wrong divisor decode or a domain left at full rate. Separate runs cover the rest: a one-cycle interrupt that a design without a held pending flag would lose, and idle commands during idle that a design might wrongly accept and use to change mode or divisor.

// File: rtl/idlediv_pkg.sv
package idlediv_pkg;

    localparam int SEL_W        = 2;
    localparam int DIV_MIN_LOG2 = 4;
    localparam int NUM_SEL      = 1 << SEL_W;
    localparam int CNT_W        = DIV_MIN_LOG2 + NUM_SEL - 1;
    localparam int NUM_DOM      = 4;

    localparam int DOM_CORE  = 0;
    localparam int DOM_SCLK  = 1;
    localparam int DOM_COUT  = 2;
    localparam int DOM_TMR   = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_NAP  = 2'd1,
        ST_SLOW = 2'd2
    } idle_state_e;

    typedef logic [SEL_W-1:0] div_sel_t;

    typedef struct packed {
        idle_state_e st;
        div_sel_t    sel;
        logic        pend;
        logic        resume;
    } seq_reg_t;

endpackage

// File: rtl/idlediv_cnt.sv
module idlediv_cnt
    import idlediv_pkg::*;
#(
    parameter int P_SEL_W    = SEL_W,
    parameter int P_MIN_LOG2 = DIV_MIN_LOG2,
    parameter int P_CNT_W    = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [P_SEL_W-1:0] sel,
    output logic [P_CNT_W-1:0] last,
    output logic               term
);
    localparam int SPAN_W = P_CNT_W + 1;

    logic [P_CNT_W-1:0] cnt;
    logic [SPAN_W-1:0]  span;

    always_comb begin
        span = SPAN_W'(1) << (P_MIN_LOG2 + int'(sel));
        last = P_CNT_W'(span - SPAN_W'(1));
    end

    assign term = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + P_CNT_W'(1);
        end
    end

    // R5: the divide count never passes the terminal value of the selected divisor
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= last));

    // R5: the count restarts from zero after a terminal cycle
    assert_cnt_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (run && term) |=> (cnt == '0));

endmodule

// File: rtl/idlediv_seq.sv
module idlediv_seq
    import idlediv_pkg::*;
#(
    parameter int P_SEL_W = SEL_W,
    parameter int P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               idle_cmd,
    input  logic               div_mode,
    input  logic [P_SEL_W-1:0] sel_in,
    input  logic               irq,
    input  logic               term,
    input  logic [P_CNT_W-1:0] last,
    output idle_state_e        st,
    output logic [P_SEL_W-1:0] sel_q,
    output logic               resume
);
    seq_reg_t q, d;
    logic [P_CNT_W:0] lat;

    always_comb begin
        d        = q;
        d.resume = 1'b0;
        case (q.st)
            ST_RUN: begin
                if (idle_cmd) begin
                    d.st   = div_mode ? ST_SLOW : ST_NAP;
                    d.sel  = div_sel_t'(sel_in);
                    d.pend = 1'b0;
                end
            end
            ST_NAP: begin
                if (irq) begin
                    d.st     = ST_RUN;
                    d.resume = 1'b1;
                end
            end
            ST_SLOW: begin
                if (irq) begin
                    d.pend = 1'b1;
                end
                if (term && (q.pend || irq)) begin
                    d.st     = ST_RUN;
                    d.resume = 1'b1;
                    d.pend   = 1'b0;
                end
            end
            default: begin
                d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st     <= ST_RUN;
            q.sel    <= '0;
            q.pend   <= 1'b0;
            q.resume <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else if ((q.st == ST_SLOW) && (q.pend || irq) && (d.st == ST_SLOW)) begin
            lat <= lat + (P_CNT_W+1)'(1);
        end else begin
            lat <= '0;
        end
    end

    assign st     = q.st;
    assign sel_q  = P_SEL_W'(q.sel);
    assign resume = q.resume;

    // R4: gated idle leaves on the edge at which the interrupt is seen
    assert_nap_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_NAP && irq) |=> (q.st == ST_RUN && q.resume));

    // R6: divided idle only ends at a terminal count
    assert_slow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_SLOW && !term) |=> (q.st == ST_SLOW));

    // R6: a pending wake never waits longer than one divide period
    assert_wake_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_SLOW) |-> (lat <= {1'b0, last}));

    // R7: resume lasts one cycle
    assert_resume_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        q.resume |=> !q.resume);

    // R8: the divisor stays fixed for the whole divided idle
    assert_sel_held_R8: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_SLOW && $past(q.st == ST_SLOW)) |-> $stable(q.sel));

    // R9: a seen interrupt stays pending until the exit
    assert_pend_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_SLOW && irq && !term) |=> q.pend);

endmodule

// File: rtl/idlediv_ena.sv
module idlediv_ena
    import idlediv_pkg::*;
#(
    parameter int P_NUM_DOM = NUM_DOM,
    parameter int P_CORE    = DOM_CORE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  idle_state_e          st,
    input  logic                 term,
    output logic [P_NUM_DOM-1:0] en
);
    for (genvar i = 0; i < P_NUM_DOM; i++) begin : g_dom
        if (i == P_CORE) begin : g_core
            assign en[i] = (st == ST_RUN) || ((st == ST_SLOW) && term);
        end else begin : g_periph
            assign en[i] = (st == ST_RUN) || (st == ST_NAP) || ((st == ST_SLOW) && term);
        end
    end

    // R2: full rate on every domain while running
    assert_run_full_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (&en));

    // R3: gated idle stops only the core
    assert_nap_core_off_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NAP) |-> (!en[P_CORE] && ($countones(en) == P_NUM_DOM - 1)));

    // R5: all domains slow down together
    assert_slow_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SLOW) |-> (en == {P_NUM_DOM{en[0]}}));

endmodule

// File: rtl/idlediv_ctrl.sv
module idlediv_ctrl
    import idlediv_pkg::*;
#(
    parameter int P_SEL_W    = SEL_W,
    parameter int P_MIN_LOG2 = DIV_MIN_LOG2,
    parameter int P_NUM_DOM  = NUM_DOM
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               idle_cmd,
    input  logic               div_mode,
    input  logic [P_SEL_W-1:0] div_sel,
    input  logic               irq,
    output logic               core_en,
    output logic               sclk_en,
    output logic               cout_en,
    output logic               tmr_en,
    output logic               resume
);
    localparam int L_CNT_W = P_MIN_LOG2 + (1 << P_SEL_W) - 1;

    idle_state_e          st;
    logic [P_SEL_W-1:0]   sel_q;
    logic [L_CNT_W-1:0]   last;
    logic                 term;
    logic [P_NUM_DOM-1:0] en;

    idlediv_seq #(
        .P_SEL_W (P_SEL_W),
        .P_CNT_W (L_CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .idle_cmd (idle_cmd),
        .div_mode (div_mode),
        .sel_in   (div_sel),
        .irq      (irq),
        .term     (term),
        .last     (last),
        .st       (st),
        .sel_q    (sel_q),
        .resume   (resume)
    );

    idlediv_cnt #(
        .P_SEL_W    (P_SEL_W),
        .P_MIN_LOG2 (P_MIN_LOG2),
        .P_CNT_W    (L_CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (st == ST_SLOW),
        .sel  (sel_q),
        .last (last),
        .term (term)
    );

    idlediv_ena #(
        .P_NUM_DOM (P_NUM_DOM),
        .P_CORE    (DOM_CORE)
    ) u_ena (
        .clk  (clk),
        .rst  (rst),
        .st   (st),
        .term (term),
        .en   (en)
    );

    assign core_en = en[DOM_CORE];
    assign sclk_en = en[DOM_SCLK];
    assign cout_en = en[DOM_COUT];
    assign tmr_en  = en[DOM_TMR];

    // R1: running state right after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (core_en && sclk_en && cout_en && tmr_en && !resume));

endmodule

// File: tb/idlediv_ctrl_test.sv
`timescale 1ns/1ps
module idlediv_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idle_cmd = 1'b0;
    logic       div_mode = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       irq = 1'b0;
    logic       core_en, sclk_en, cout_en, tmr_en, resume;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    idlediv_ctrl uut (
        .clk(clk), .rst(rst), .idle_cmd(idle_cmd), .div_mode(div_mode),
        .div_sel(div_sel), .irq(irq), .core_en(core_en), .sclk_en(sclk_en),
        .cout_en(cout_en), .tmr_en(tmr_en), .resume(resume)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, cycles %0d expected < %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int en_vec();
        return {28'd0, tmr_en, cout_en, sclk_en, core_en};
    endfunction

    task automatic enter(input logic mode, input logic [1:0] sel);
        idle_cmd = 1'b1;
        div_mode = mode;
        div_sel  = sel;
        step();
        idle_cmd = 1'b0;
        div_mode = ~mode;
        div_sel  = ~sel;
    endtask

    // divided idle: wait d cycles, raise irq (held or one cycle), measure latency
    task automatic slow_run(input logic [1:0] sel, input int d, input bit pulse, input bit disturb);
        int n = 16 << sel;
        int pulses = 0;
        int mism = 0;
        int lat = 0;
        int prev_core;
        enter(1'b1, sel);
        check("R5 entry core_en low", core_en, 0);
        for (int j = 1; j <= d; j++) begin
            if (disturb && j == 1) begin
                idle_cmd = 1'b1; div_mode = 1'b0; div_sel = ~sel;
            end
            step();
            idle_cmd = 1'b0;
            if (core_en) pulses++;
            if (en_vec() != (core_en ? 15 : 0)) mism++;
        end
        check("R5 pulse count", pulses, (d + 1) / n);
        check("R5 domains aligned", mism, 0);
        irq = 1'b1;
        prev_core = core_en;
        while (lat < 400) begin
            step();
            if (pulse) irq = 1'b0;
            lat++;
            if (resume) break;
            prev_core = core_en;
        end
        irq = 1'b0;
        if (disturb) check("R8 divisor held, latency", lat, n - (d % n));
        else if (pulse) check("R9 pulsed irq latency", lat, n - (d % n));
        else check("R6 wake latency", lat, n - (d % n));
        check("R6 full pulse before resume", prev_core, 1);
        check("R7 enables full on resume", en_vec(), 15);
        step();
        check("R7 resume single cycle", resume, 0);
        check("R7 running after resume", en_vec(), 15);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        check("R1 reset enables", en_vec(), 15);
        check("R1 reset resume", resume, 0);

        irq = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R2 irq ignored when running", resume, 0);
            check("R2 full rate", en_vec(), 15);
        end
        irq = 1'b0;

        // gated idle
        for (int d = 0; d < 6; d += 5) begin
            enter(1'b0, 2'b11);
            for (int k = 0; k < d; k++) begin
                if (k == 1) begin idle_cmd = 1'b1; div_mode = 1'b1; end
                step();
                idle_cmd = 1'b0; div_mode = 1'b0;
            end
            check("R3 core gated", core_en, 0);
            check("R3 peripherals running", en_vec(), 14);
            if (d > 0) check("R8 no switch to divided", en_vec(), 14);
            irq = 1'b1;
            step();
            check("R4 wake in one cycle", resume, 1);
            check("R4 core back", core_en, 1);
            irq = 1'b0;
            step();
            check("R7 gated resume single cycle", resume, 0);
        end

        // divided idle sweep over all divisors and phases
        for (int s = 0; s < 4; s++) begin
            int n = 16 << s;
            int ds[7] = '{0, 1, n / 2, n - 1, n, n + 3, 2 * n - 1};
            foreach (ds[i]) slow_run(2'(s), ds[i], 1'b0, 1'b0);
            slow_run(2'(s), n / 4 + 1, 1'b1, 1'b0);
            slow_run(2'(s), n + 2, 1'b0, 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule